// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block gathers up to 32 interrupt request lines and presents them to a processor as one interrupt output. Each request line is first synchronized to the block clock. It is then captured into a per-source status bit. Whether a line is treated as edge or level sensitive is fixed at build time by a kind mask. A per-source enable mask gates the captured requests into a pending set. A two-bit master enable decides whether any pending request reaches the processor.

Software works through a small single-cycle register port: a write strobe, a 3-bit word address, and 32-bit write and read data. Reads are combinational from the address. Through this port software can read status, pending and enable. It can replace the enable mask or change it atomically through separate set and clear registers. It acknowledges requests with a write mask. A vector register returns the index of the lowest-numbered pending source, or all-ones when none is pending. The asynchronous active-low reset is released synchronously inside the block, two clocks after the reset input rises.

Top module: `vecint_ctrl`

## Requirements
- R1: After reset, status (word 0), enable (word 2) and master enable (word 7) read zero, the vector register (word 6) reads 0xFFFFFFFF, and `irq_out` is low.
- R2: A write to word 2 replaces the enable mask. A write to word 4 ORs the data into the enable mask. A write to word 5 clears the enable bits where the data bit is 1. In the set and clear cases all other enable bits keep their value.
- R3: A write to word 3 clears every status bit whose data bit is 1 and leaves the other status bits alone. Writing 0xFFFFFFFF clears all captured requests whose inputs are no longer asserting them.
- R4: A source whose kind-mask bit is 0 is level sensitive. Its status bit is set on every cycle its synchronized input is high. If it is acknowledged while the input is still high, it reads set again.
- R5: A source whose kind-mask bit is 1 is edge sensitive. Its status bit is set only on a rising edge of its synchronized input. Once acknowledged, it stays clear while the input remains high.
- R6: Word 1 (pending) reads as status AND enable.
- R7: The master enable occupies bits [1:0] of word 7. `irq_out` is high exactly when at least one pending bit is set and both master-enable bits are 1.
- R8: Word 6 returns the zero-extended index of the lowest-numbered pending source. It returns 0xFFFFFFFF when nothing is pending.
- R9: Writes to words 0, 1 and 6 change nothing. Reads of words 3, 4 and 5 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_in | input | NUM_SRC | Interrupt request lines, asynchronous |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that races a request line that is still asserted. A level source must re-latch in that case, while an edge source must stay cleared. The bench holds a level line and an edge line high across the acknowledge write. It samples status just after that write and again several cycles later, so the result cannot be mistaken for capture latency. The priority choice is reached by leaving two sources pending at once and then acknowledging the lower one, which makes the vector move to the next index.

// File: rtl/vecint_pkg.sv
package vecint_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    OFS_STATUS = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_ENABLE = 3'd2,
    OFS_ACK    = 3'd3,
    OFS_SETEN  = 3'd4,
    OFS_CLREN  = 3'd5,
    OFS_VECTOR = 3'd6,
    OFS_MASTER = 3'd7
  } reg_ofs_e;

endpackage

// File: rtl/vecint_capture.sv
module vecint_capture #(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0000_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               ack_we,
  input  logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] status
);

  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q;
  logic [NUM_SRC-1:0] rise_vec, set_vec, status_d;
  logic [NUM_SRC-1:0] level_mask;
  logic               status_en;

  assign rise_vec = sync_q & ~prev_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_kind
    if (EDGE_KIND[i]) begin : g_edge
      assign set_vec[i]    = rise_vec[i];
      assign level_mask[i] = 1'b0;
    end else begin : g_level
      assign set_vec[i]    = sync_q[i];
      assign level_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= irq_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    status_en = ack_we | (|set_vec);
    status_d  = status;
    if (ack_we) status_d = status_d & ~ack_mask;
    status_d  = status_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= '0;
    else if (status_en) status <= status_d;
  end

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((status & $past(ack_mask & ~set_vec)) == '0));

  p_level_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sync_q & level_mask) != '0) |=>
      ((status & $past(sync_q & level_mask)) == $past(sync_q & level_mask)));

endmodule

// File: rtl/vecint_regs.sv
module vecint_regs #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               set_wr,
  input  logic               clr_wr,
  input  logic               mst_wr,
  input  logic [NUM_SRC-1:0] wmask,
  input  logic [1:0]         wmst,
  output logic [NUM_SRC-1:0] enable,
  output logic [1:0]         master
);

  logic [NUM_SRC-1:0] enable_d;
  logic               enable_en;

  always_comb begin
    enable_en = en_wr | set_wr | clr_wr;
    enable_d  = enable;
    if (en_wr)       enable_d = wmask;
    else if (set_wr) enable_d = enable | wmask;
    else if (clr_wr) enable_d = enable & ~wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable <= '0;
    else if (enable_en) enable <= enable_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      master <= 2'b00;
    else if (mst_wr) master <= wmst;
  end

  p_set_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (((enable & $past(wmask)) == $past(wmask)) &&
               ((enable & ~$past(wmask)) == ($past(enable) & ~$past(wmask)))));

  p_clr_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (((enable & $past(wmask)) == '0) &&
               ((enable & ~$past(wmask)) == ($past(enable) & ~$past(wmask)))));

endmodule

// File: rtl/vecint_prio.sv
module vecint_prio #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic               found,
  output logic [IDX_W-1:0]   index
);

  always_comb begin
    found = 1'b0;
    index = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found = 1'b1;
        index = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vecint_ctrl.sv
module vecint_ctrl
  import vecint_pkg::*;
#(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_KIND = 32'h0000_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               rst_meta_q, rst_sync_n;
  logic [NUM_SRC-1:0] status, enable, pending;
  logic [1:0]         master;
  logic               vec_found;
  logic [IDX_W-1:0]   vec_index;
  logic [DATA_W-1:0]  vector;
  logic               ack_we, en_wr, set_wr, clr_wr, mst_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    ack_we = reg_we && (reg_addr == OFS_ACK);
    en_wr  = reg_we && (reg_addr == OFS_ENABLE);
    set_wr = reg_we && (reg_addr == OFS_SETEN);
    clr_wr = reg_we && (reg_addr == OFS_CLREN);
    mst_wr = reg_we && (reg_addr == OFS_MASTER);
  end

  vecint_capture #(.NUM_SRC(NUM_SRC), .EDGE_KIND(EDGE_KIND)) u_capture (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .irq_in   (irq_in),
    .ack_we   (ack_we),
    .ack_mask (reg_wdata[NUM_SRC-1:0]),
    .status   (status)
  );

  vecint_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_wr  (en_wr),
    .set_wr (set_wr),
    .clr_wr (clr_wr),
    .mst_wr (mst_wr),
    .wmask  (reg_wdata[NUM_SRC-1:0]),
    .wmst   (reg_wdata[1:0]),
    .enable (enable),
    .master (master)
  );

  assign pending = status & enable;

  vecint_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pending (pending),
    .found   (vec_found),
    .index   (vec_index)
  );

  assign vector  = vec_found ? DATA_W'(vec_index) : '1;
  assign irq_out = (|pending) && (master == 2'b11);

  always_comb begin
    unique case (reg_addr)
      OFS_STATUS: reg_rdata = DATA_W'(status);
      OFS_PEND:   reg_rdata = DATA_W'(pending);
      OFS_ENABLE: reg_rdata = DATA_W'(enable);
      OFS_VECTOR: reg_rdata = vector;
      OFS_MASTER: reg_rdata = DATA_W'(master);
      default:    reg_rdata = '0;
    endcase
  end

  p_vec_pending_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vector != '1) |-> pending[vec_index]);

  p_irq_needs_vec_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_out |-> (vector != '1));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (!irq_out && (master == 2'b00) && (enable == '0)));

endmodule

// File: tb/vecint_ctrl_tb_top.sv
module vecint_ctrl_tb_top;

  localparam int NSRC = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = 3'd0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NSRC-1:0] irq_in = '0;
  logic            irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vecint_ctrl #(.NUM_SRC(NSRC), .EDGE_KIND(32'h0000_FFFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R1 status", v, 32'h0);
    rd(3'd2, v); check("R1 enable", v, 32'h0);
    rd(3'd7, v); check("R1 master", v, 32'h0);
    rd(3'd6, v); check("R1 vector", v, 32'hFFFF_FFFF);
    check("R1 irq_out", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic t_enable_ops;
    logic [31:0] v;
    wr(3'd2, 32'h0000_00F0); rd(3'd2, v); check("R2 write enable", v, 32'h0000_00F0);
    wr(3'd4, 32'h8000_0003); rd(3'd2, v); check("R2 set enable", v, 32'h8000_00F3);
    wr(3'd5, 32'h8000_0030); rd(3'd2, v); check("R2 clear enable", v, 32'h0000_00C3);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R9 status write ignored", v, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); check("R9 pending write ignored", v, 32'h0);
    wr(3'd6, 32'h0000_0004); rd(3'd6, v); check("R9 vector write ignored", v, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R9 enable untouched", v, 32'h0000_00C3);
    rd(3'd3, v); check("R9 ack reads zero", v, 32'h0);
    rd(3'd4, v); check("R9 set-enable reads zero", v, 32'h0);
    rd(3'd5, v); check("R9 clear-enable reads zero", v, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    irq_in[2] = 1'b1; wait_cyc(4);
    rd(3'd0, v); check("R5 edge captured", v, 32'h0000_0004);
    wr(3'd3, 32'h0000_0004);
    rd(3'd0, v); check("R5 edge acked while high", v, 32'h0);
    wait_cyc(5);
    rd(3'd0, v); check("R5 edge stays clear", v, 32'h0);
    irq_in[2] = 1'b0; wait_cyc(4);
  endtask

  task automatic t_level;
    logic [31:0] v;
    irq_in[20] = 1'b1; wait_cyc(4);
    rd(3'd0, v); check("R4 level captured", v, 32'h0010_0000);
    wr(3'd3, 32'h0010_0000);
    rd(3'd0, v); check("R4 level relatches", v, 32'h0010_0000);
    wait_cyc(5);
    rd(3'd0, v); check("R4 level still set", v, 32'h0010_0000);
    irq_in[20] = 1'b0; wait_cyc(4);
    wr(3'd3, 32'h0010_0000);
    rd(3'd0, v); check("R4 level clears after release", v, 32'h0);
  endtask

  task automatic t_pending_irq;
    logic [31:0] v;
    irq_in[5] = 1'b1; irq_in[9] = 1'b1; wait_cyc(4);
    irq_in[5] = 1'b0; irq_in[9] = 1'b0; wait_cyc(4);
    rd(3'd0, v); check("R5 two edges captured", v, 32'h0000_0220);
    wr(3'd2, 32'h0000_0200);
    rd(3'd1, v); check("R6 pending is status and enable", v, 32'h0000_0200);
    wr(3'd7, 32'h0);
    #1 check("R7 irq low master 0", {31'd0, irq_out}, 32'h0);
    wr(3'd7, 32'h1);
    #1 check("R7 irq low master 1", {31'd0, irq_out}, 32'h0);
    wr(3'd7, 32'h3);
    rd(3'd7, v); check("R7 master readback", v, 32'h3);
    #1 check("R7 irq high", {31'd0, irq_out}, 32'h1);
    wr(3'd2, 32'h0);
    #1 check("R7 irq low when all masked", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic t_vector;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd6, v); check("R8 lowest of two", v, 32'd5);
    wr(3'd3, 32'h0000_0020);
    rd(3'd0, v); check("R3 partial ack", v, 32'h0000_0200);
    rd(3'd6, v); check("R8 next source", v, 32'd9);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R3 ack all", v, 32'h0);
    rd(3'd6, v); check("R8 none pending", v, 32'hFFFF_FFFF);
    #1 check("R7 irq low after ack all", {31'd0, irq_out}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_enable_ops();
    t_ignored();
    wr(3'd2, 32'h0);
    t_edge();
    t_level();
    t_pending_irq();
    t_vector();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule